// File: doc/BRIEF.md
# CAN Dominant Timeout Guard

This block sits between a CAN protocol controller and the line driver/receiver of a node. It keeps watch on two signals. The first is the transmit request from the controller, which is active low: TXD low asks for a dominant bus. The second is the sampled bus state coming back from the receiver. Both inputs pass through a two-flop synchronizer. The guard then passes them on to the driver and to the controller.

A stuck-low transmit request would lock the whole network dominant. To prevent this, the guard forces the driver request off once the request has stayed dominant for a configured number of clock cycles. The driver stays off until the controller itself returns TXD high. A bus that stays dominant too long would keep the controller's receive input low forever. To prevent this, the guard forces the receive output high after a second configured window. That path recovers by itself as soon as the bus goes recessive again.

Each path has a fault output. It is high exactly while that path is forcing its output. Both windows are parameters counted in clock cycles. They must be set longer than eleven bit times at the slowest bit rate the system uses.

Top module: `can_dto_guard`

## Requirements
- R1: While reset is high, and on the first cycles after it, the guard holds the outputs at their reset values: drv_dom_o = 0, rxd_o = 1, tx_fault_o = 0 and rx_fault_o = 0. Reset also clears both timeout counts, so a dominant run that was in progress before reset starts a fresh window afterwards.
- R2: drv_dom_o (1 = drive dominant) follows the inverse of txd_n_i (0 = dominant request), with a latency of two clock edges.
- R3: Once the synchronized request has been dominant for TX_LIMIT consecutive cycles, drv_dom_o goes to 0 and tx_fault_o goes to 1. This happens on edge TX_LIMIT+2 after txd_n_i falls.
- R4: After a transmit timeout, drv_dom_o stays 0 and tx_fault_o stays 1 for as long as txd_n_i stays low. This holds however long the request lasts (the count cannot wrap) and whatever the bus does. Both outputs release two edges after txd_n_i goes high.
- R5: rxd_o follows the inverse of bus_dom_i (1 = dominant bus gives rxd_o = 0), with a latency of two clock edges.
- R6: Once the synchronized bus has been dominant for RX_LIMIT consecutive cycles, rxd_o is forced to 1 and rx_fault_o goes to 1. This happens on edge RX_LIMIT+2 after bus_dom_i rises.
- R7: The receive path releases by itself two edges after bus_dom_i returns to 0: rx_fault_o falls and rxd_o follows the bus again. No change on txd_n_i is needed.
- R8: A single synchronized recessive cycle on either path restarts that path's count. The next dominant run then gets a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_n_i | input | 1 | Transmit request from controller, 0 = dominant |
| bus_dom_i | input | 1 | Sampled bus state, 1 = dominant |
| drv_dom_o | output | 1 | Driver request, 1 = drive dominant |
| rxd_o | output | 1 | Receive data to controller, 0 = dominant |
| tx_fault_o | output | 1 | High while the transmit timeout is holding the driver off |
| rx_fault_o | output | 1 | High while the receive timeout is forcing rxd_o high |

## Verification
Suppose a count fails to clear on a recessive cycle, or wraps past its limit. The driver request or the receive output then changes at the wrong edge, and the bench sees this at the first sample after the expected edge. This is either one cycle early on a restarted run, or a dominant request that comes back during a long stuck-low hold. A transmit lock that is wrongly cleared by the bus going recessive would show drv_dom_o returning to 1 while txd_n_i is still low. That shows within two edges of the bus release.

// File: rtl/can_dto_pkg.sv
package can_dto_pkg;

    // Width of a counter that must hold values 0..limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    // Where a monitored line sits within its dominant window.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_EXPIRED = 2'd2
    } phase_e;

    // Synchronized view of the two monitored lines.
    typedef struct packed {
        logic tx_dom;
        logic bus_dom;
    } line_view_t;

    typedef struct packed {
        logic drv_dom;
        logic rxd;
        logic tx_fault;
        logic rx_fault;
    } guard_out_t;

    // Synchronizer reset value: TXD high (recessive), bus recessive.
    localparam logic [1:0] SYNC_RST = 2'b10;

endpackage

// File: rtl/dto_sync.sv
module dto_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dto_timer.sv
module dto_timer
    import can_dto_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   dom,
    output phase_e phase
);
    localparam int unsigned CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] count;
    logic          at_top;

    assign at_top = (count == TOP);

    always_ff @(posedge clk) begin
        if (rst || !dom) begin
            count <= '0;
        end else if (!at_top) begin
            count <= count + 1'b1;
        end
    end

    always_comb begin
        if (!dom)        phase = PH_IDLE;
        else if (at_top) phase = PH_EXPIRED;
        else             phase = PH_ACTIVE;
    end
endmodule

// File: rtl/can_dto_guard.sv
module can_dto_guard
    import can_dto_pkg::*;
#(
    parameter int unsigned TX_LIMIT = 240000,
    parameter int unsigned RX_LIMIT = 320000
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_n_i,
    input  logic bus_dom_i,
    output logic drv_dom_o,
    output logic rxd_o,
    output logic tx_fault_o,
    output logic rx_fault_o
);
    localparam int NPATH = 2;
    localparam int unsigned LIMS [NPATH] = '{TX_LIMIT, RX_LIMIT};

    logic [1:0] sync_q;
    line_view_t view;
    phase_e     ph [NPATH];
    logic       dom [NPATH];
    guard_out_t outs;

    dto_sync #(.W(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({txd_n_i, bus_dom_i}),
        .q   (sync_q)
    );

    assign view.tx_dom  = ~sync_q[1];
    assign view.bus_dom = sync_q[0];
    assign dom[0] = view.tx_dom;
    assign dom[1] = view.bus_dom;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        dto_timer #(.LIMIT(LIMS[p])) u_timer (
            .clk   (clk),
            .rst   (rst),
            .dom   (dom[p]),
            .phase (ph[p])
        );
    end

    always_comb begin
        outs.drv_dom  = (ph[0] == PH_ACTIVE);
        outs.tx_fault = (ph[0] == PH_EXPIRED);
        outs.rxd      = (ph[1] != PH_ACTIVE);
        outs.rx_fault = (ph[1] == PH_EXPIRED);
    end

    assign drv_dom_o  = outs.drv_dom;
    assign rxd_o      = outs.rxd;
    assign tx_fault_o = outs.tx_fault;
    assign rx_fault_o = outs.rx_fault;
endmodule

// File: rtl/can_dto_checker.sv
module can_dto_checker #(
    parameter int unsigned TX_LIMIT = 240000,
    parameter int unsigned RX_LIMIT = 320000
) (
    input logic clk,
    input logic rst,
    input logic txd_n_i,
    input logic bus_dom_i,
    input logic drv_dom_o,
    input logic rxd_o,
    input logic tx_fault_o,
    input logic rx_fault_o
);
    int unsigned drv_run;
    int unsigned rxl_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_run <= 0;
            rxl_run <= 0;
        end else begin
            drv_run <= drv_dom_o ? drv_run + 1 : 0;
            rxl_run <= !rxd_o ? rxl_run + 1 : 0;
        end
    end

    AST_DRV_NEEDS_TXD_LOW: assert property (@(posedge clk) disable iff (rst)
        drv_dom_o |-> !$past(txd_n_i, 2)); // R2
    AST_TX_WINDOW: assert property (@(posedge clk) disable iff (rst)
        drv_dom_o |-> (drv_run < TX_LIMIT)); // R3
    AST_TX_RELEASE_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_fault_o) |-> (!drv_dom_o && $past(txd_n_i, 2))); // R4
    AST_RXD_LOW_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
        !rxd_o |-> $past(bus_dom_i, 2)); // R5
    AST_RX_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !rxd_o |-> (rxl_run < RX_LIMIT)); // R6
    AST_RX_SELF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_fault_o) |-> (rxd_o && !$past(bus_dom_i, 2))); // R7
    AST_FAULT_FORCES_RXD: assert property (@(posedge clk) disable iff (rst)
        rx_fault_o |-> rxd_o); // R6
endmodule

bind can_dto_guard can_dto_checker #(.TX_LIMIT(TX_LIMIT), .RX_LIMIT(RX_LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .txd_n_i    (txd_n_i),
    .bus_dom_i  (bus_dom_i),
    .drv_dom_o  (drv_dom_o),
    .rxd_o      (rxd_o),
    .tx_fault_o (tx_fault_o),
    .rx_fault_o (rx_fault_o)
);

// File: tb/tb_can_dto_guard.sv
`timescale 1ns/1ps
module tb_can_dto_guard;
    localparam int unsigned TXL = 16;
    localparam int unsigned RXL = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txd_n = 1'b1;
    logic bus_dom = 1'b0;
    logic drv_dom, rxd, tx_fault, rx_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    can_dto_guard #(.TX_LIMIT(TXL), .RX_LIMIT(RXL)) dut (
        .clk (clk), .rst (rst), .txd_n_i (txd_n), .bus_dom_i (bus_dom),
        .drv_dom_o (drv_dom), .rxd_o (rxd), .tx_fault_o (tx_fault), .rx_fault_o (rx_fault)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        txd;
        logic        bus;
        logic [15:0] n;
        logic        e_drv;
        logic        e_rxd;
        logic        e_tf;
        logic        e_rf;
    } vec_t;

    localparam int NV = 29;
    // fields: req, txd_n, bus_dom, edges to wait, drv, rxd, tx_fault, rx_fault
    localparam vec_t VECS [NV] = '{
        '{8'd1, 1'b1, 1'b0, 16'd4,   1'b0, 1'b1, 1'b0, 1'b0}, // R1 idle after reset
        '{8'd2, 1'b0, 1'b0, 16'd1,   1'b0, 1'b1, 1'b0, 1'b0}, // R2 one edge: not yet
        '{8'd2, 1'b0, 1'b0, 16'd1,   1'b1, 1'b1, 1'b0, 1'b0}, // R2 second edge: dominant
        '{8'd3, 1'b0, 1'b0, 16'd14,  1'b1, 1'b1, 1'b0, 1'b0}, // R3 count 14
        '{8'd3, 1'b0, 1'b0, 16'd1,   1'b1, 1'b1, 1'b0, 1'b0}, // R3 last dominant cycle
        '{8'd3, 1'b0, 1'b0, 16'd1,   1'b0, 1'b1, 1'b1, 1'b0}, // R3 timed out
        '{8'd6, 1'b0, 1'b1, 16'd30,  1'b0, 1'b1, 1'b1, 1'b1}, // R6 bus stuck, tx locked
        '{8'd4, 1'b0, 1'b0, 16'd2,   1'b0, 1'b1, 1'b1, 1'b0}, // R4 bus release keeps tx lock
        '{8'd4, 1'b1, 1'b0, 16'd1,   1'b0, 1'b1, 1'b1, 1'b0}, // R4 txd high, one edge
        '{8'd4, 1'b1, 1'b0, 16'd1,   1'b0, 1'b1, 1'b0, 1'b0}, // R4 released
        '{8'd4, 1'b0, 1'b0, 16'd2,   1'b1, 1'b1, 1'b0, 1'b0}, // R4 re-armed
        '{8'd2, 1'b1, 1'b0, 16'd2,   1'b0, 1'b1, 1'b0, 1'b0}, // R2 recessive
        '{8'd5, 1'b1, 1'b1, 16'd2,   1'b0, 1'b0, 1'b0, 1'b0}, // R5 bus dominant
        '{8'd6, 1'b1, 1'b1, 16'd23,  1'b0, 1'b0, 1'b0, 1'b0}, // R6 count 23
        '{8'd6, 1'b1, 1'b1, 16'd1,   1'b0, 1'b1, 1'b0, 1'b1}, // R6 timed out
        '{8'd7, 1'b1, 1'b0, 16'd1,   1'b0, 1'b1, 1'b0, 1'b1}, // R7 one edge
        '{8'd7, 1'b1, 1'b0, 16'd1,   1'b0, 1'b1, 1'b0, 1'b0}, // R7 self release
        '{8'd7, 1'b1, 1'b1, 16'd2,   1'b0, 1'b0, 1'b0, 1'b0}, // R7 follows again
        '{8'd5, 1'b1, 1'b0, 16'd2,   1'b0, 1'b1, 1'b0, 1'b0}, // R5 recessive
        '{8'd8, 1'b0, 1'b0, 16'd12,  1'b1, 1'b1, 1'b0, 1'b0}, // R8 count 10
        '{8'd8, 1'b1, 1'b0, 16'd1,   1'b1, 1'b1, 1'b0, 1'b0}, // R8 glitch in sync
        '{8'd8, 1'b0, 1'b0, 16'd1,   1'b0, 1'b1, 1'b0, 1'b0}, // R8 recessive cycle seen
        '{8'd8, 1'b0, 1'b0, 16'd1,   1'b1, 1'b1, 1'b0, 1'b0}, // R8 count restarted
        '{8'd8, 1'b0, 1'b0, 16'd15,  1'b1, 1'b1, 1'b0, 1'b0}, // R8 full window again
        '{8'd3, 1'b0, 1'b0, 16'd1,   1'b0, 1'b1, 1'b1, 1'b0}, // R3 timed out
        '{8'd4, 1'b0, 1'b0, 16'd200, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 long hold, no wrap
        '{8'd4, 1'b0, 1'b1, 16'd3,   1'b0, 1'b0, 1'b1, 1'b0}, // R4 bus activity ignored
        '{8'd4, 1'b1, 1'b0, 16'd2,   1'b0, 1'b1, 1'b0, 1'b0}, // R4 released
        '{8'd1, 1'b1, 1'b0, 16'd2,   1'b0, 1'b1, 1'b0, 1'b0}  // R1 quiet end of table
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {drv,rxd,tf,rf} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state with dominant inputs applied
        txd_n = 1'b0;
        bus_dom = 1'b1;
        wait_edges(3);
        check("R1 in reset", {drv_dom, rxd, tx_fault, rx_fault}, 4'b0100);
        txd_n = 1'b1;
        bus_dom = 1'b0;
        rst = 1'b0;
        wait_edges(1);

        for (int i = 0; i < NV; i++) begin
            txd_n   = VECS[i].txd;
            bus_dom = VECS[i].bus;
            wait_edges(int'(VECS[i].n));
            check($sformatf("R%0d vec %0d", VECS[i].req, i),
                  {drv_dom, rxd, tx_fault, rx_fault},
                  {VECS[i].e_drv, VECS[i].e_rxd, VECS[i].e_tf, VECS[i].e_rf});
        end

        // R1: reset during a transmit lock clears it and restarts the window
        txd_n = 1'b0;
        wait_edges(20);
        check("R3 lock before reset", {drv_dom, rxd, tx_fault, rx_fault}, 4'b0110);
        rst = 1'b1;
        wait_edges(2);
        check("R1 reset clears lock", {drv_dom, rxd, tx_fault, rx_fault}, 4'b0100);
        rst = 1'b0;
        wait_edges(1);
        check("R1 first edge after reset", {drv_dom, rxd, tx_fault, rx_fault}, 4'b0100);
        wait_edges(1);
        check("R1 fresh window", {drv_dom, rxd, tx_fault, rx_fault}, 4'b1100);
        wait_edges(int'(TXL) - 1);
        check("R3 fresh window end", {drv_dom, rxd, tx_fault, rx_fault}, 4'b1100);
        wait_edges(1);
        check("R3 fresh window expiry", {drv_dom, rxd, tx_fault, rx_fault}, 4'b0110);
        txd_n = 1'b1;
        wait_edges(2);
        check("R4 final release", {drv_dom, rxd, tx_fault, rx_fault}, 4'b0100);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule